// File: doc/BRIEF.md
# Shift Unit with Status Flags

This block shifts an operand left logically, right logically or right arithmetically on an 8, 16 or 32 bit operand size, and produces the shifted value together with an updated status flag word in the familiar carry, parity, adjust, zero, sign and overflow layout. It sits behind the operand read stage of an integer execution pipe. The caller presents the operand, a shift count, an operation code, a size code and the current flag word with a valid strobe. One clock later the unit returns the result, the new flag word and a matching valid strobe.

Only the low five bits of the count take part. A count of zero is a true no-op for the flags: the incoming word comes back exactly as it went in. For a non-zero count, carry is the last bit shifted out. Overflow follows the exclusive-OR of the top bits before and after the final one-bit step when the count is one, and is driven to zero for larger counts. Zero, sign and parity come from the result. Adjust is cleared. Every other flag bit passes straight through.

Top module: `shift_flag_unit`

## Requirements
- R1: `outValid` rises on the clock edge that samples `inValid` high and is low after an edge that samples it low. `result` and `flagsOut` update on the same edge as `outValid`.
- R2: Only `shiftCount[4:0]` is used. Bits above bit 4 have no effect, so a count of 33 behaves exactly like a count of 1.
- R3: When `shiftCount[4:0]` is 0, `result` is the operand masked to the selected width and `flagsOut` equals `flagsIn` bit for bit.
- R4: A left shift (`opSel` 0, or 3 as an alias) fills with zeros from the bottom. Carry (flag bit 0) is the last bit shifted out of the selected width, and is 0 once the count exceeds the width.
- R5: `opSel` 1 is a logical right shift with zero fill. `opSel` 2 is an arithmetic right shift that fills with the operand's sign bit taken at the selected width. For both, carry is the last bit shifted out at bit 0.
- R6: Overflow (flag bit 11) is 0 whenever the count is greater than 1. At count 1 it is: carry XOR result MSB for a left shift, the operand MSB for a logical right shift, and 0 for an arithmetic right shift.
- R7: For a non-zero count, zero (bit 6) is set when the result is zero within the width, sign (bit 7) is the result MSB within the width, parity (bit 2) is set when `result[7:0]` holds an even number of ones, and adjust (bit 4) is 0.
- R8: For a non-zero count, flag bits other than 0, 2, 4, 6, 7 and 11 equal the corresponding bits of `flagsIn`.
- R9: `sizeSel` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the width are ignored, and `result` bits above the width are 0.
- R10: While `inValid` is low, `result` and `flagsOut` hold their previous values whatever the other inputs do.
- R11: After reset, `outValid`, `result` and `flagsOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe; samples all operands |
| operand | input | 32 | Value to shift |
| shiftCount | input | 8 | Shift amount; low five bits used |
| opSel | input | 2 | 0 left, 1 logical right, 2 arithmetic right, 3 left |
| sizeSel | input | 2 | 0 byte, 1 half word, 2/3 word |
| flagsIn | input | 16 | Incoming status flag word |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| result | output | 32 | Shifted value, zero above the width |
| flagsOut | output | 16 | Updated status flag word |

## Verification
A wrong width decode or a bad count-minus-one intermediate shows up on the first returned request as a wrong carry or overflow bit, or as stray bits above the width. The result register has only one stage, so any such fault is visible on the cycle right after the request. A stuck load strobe shows up as outputs that drift while `inValid` is low, and this is seen one cycle after the inputs change. Count sweeps over all sizes and shift kinds, with two sign polarities of the operand, exercise the carry position at the width boundary and past it.

// File: rtl/shift_flag_pkg.sv
package shift_flag_pkg;

  localparam int CNT_BITS = 5;

  // flag word bit positions (consumers decode these)
  localparam int CARRY_POS  = 0;
  localparam int PARITY_POS = 2;
  localparam int ADJUST_POS = 4;
  localparam int ZERO_POS   = 6;
  localparam int SIGN_POS   = 7;
  localparam int OVFL_POS   = 11;

  typedef enum logic [1:0] {
    OP_SHL     = 2'd0,
    OP_SHR     = 2'd1,
    OP_SAR     = 2'd2,
    OP_SHL_ALT = 2'd3
  } shiftOp_e;

  typedef enum logic [1:0] {
    SZ_BYTE     = 2'd0,
    SZ_HALF     = 2'd1,
    SZ_WORD     = 2'd2,
    SZ_WORD_ALT = 2'd3
  } sizeSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                load;
    logic                zeroCnt;
    logic                oneCnt;
    logic                leftDir;
    logic                arith;
    sizeSel_e            widthCode;
    logic [CNT_BITS-1:0] amount;
  } shiftStrobe_t;

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_flag_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [COUNT_W-1:0] countIn,
  input  logic [1:0]         opSel,
  input  logic [1:0]         sizeSel,
  output shiftStrobe_t       strobe,
  output logic               outValid
);

  logic [CNT_BITS-1:0] amount;
  logic                unusedCountHigh;

  assign amount          = countIn[CNT_BITS-1:0];
  assign unusedCountHigh = ^countIn[COUNT_W-1:CNT_BITS];

  always_comb begin
    strobe.load      = inValid;
    strobe.amount    = amount;
    strobe.zeroCnt   = (amount == '0);
    strobe.oneCnt    = (amount == CNT_BITS'(1));
    strobe.widthCode = sizeSel_e'(sizeSel);
    strobe.arith     = (shiftOp_e'(opSel) == OP_SAR);
    strobe.leftDir   = (shiftOp_e'(opSel) == OP_SHL) ||
                       (shiftOp_e'(opSel) == OP_SHL_ALT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_fall_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_op_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> !(strobe.leftDir && strobe.arith));

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLAG_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobe_t      strobe,
  input  logic [DATA_W-1:0] operand,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagsOut
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] widthMask;
  logic [DATA_W-1:0] signExt;
  logic [IDX_W-1:0]  topIdx;
  logic [DATA_W-1:0] opMasked;
  logic [DATA_W-1:0] stepBefore;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] resMasked;
  logic [DATA_W-1:0] nextResult;
  logic [FLAG_W-1:0] nextFlags;
  logic [CNT_BITS-1:0] amountLess;
  logic              carryBit;
  logic              ovflBit;

  // width decode and sign extension from the chosen width
  always_comb begin
    unique case (strobe.widthCode)
      SZ_BYTE: begin
        widthMask = DATA_W'({8{1'b1}});
        topIdx    = IDX_W'(7);
        signExt   = {{(DATA_W-8){operand[7]}}, operand[7:0]};
      end
      SZ_HALF: begin
        widthMask = DATA_W'({16{1'b1}});
        topIdx    = IDX_W'(15);
        signExt   = {{(DATA_W-16){operand[15]}}, operand[15:0]};
      end
      default: begin
        widthMask = '1;
        topIdx    = IDX_W'(DATA_W-1);
        signExt   = operand;
      end
    endcase
  end

  assign opMasked   = operand & widthMask;
  assign amountLess = strobe.amount - CNT_BITS'(1);

  // intermediate after count-1 steps and the final value
  always_comb begin
    if (strobe.leftDir) begin
      stepBefore = opMasked << amountLess;
      shifted    = opMasked << strobe.amount;
    end else if (strobe.arith) begin
      stepBefore = DATA_W'($signed(signExt) >>> amountLess);
      shifted    = DATA_W'($signed(signExt) >>> strobe.amount);
    end else begin
      stepBefore = opMasked >> amountLess;
      shifted    = opMasked >> strobe.amount;
    end
  end

  assign resMasked = shifted & widthMask;
  assign carryBit  = strobe.leftDir ? stepBefore[topIdx] : stepBefore[0];
  assign ovflBit   = strobe.oneCnt & (stepBefore[topIdx] ^ resMasked[topIdx]);

  always_comb begin
    nextFlags  = flagsIn;
    nextResult = opMasked;
    if (!strobe.zeroCnt) begin
      nextResult             = resMasked;
      nextFlags[CARRY_POS]   = carryBit;
      nextFlags[PARITY_POS]  = ~^resMasked[7:0];
      nextFlags[ADJUST_POS]  = 1'b0;
      nextFlags[ZERO_POS]    = (resMasked == '0);
      nextFlags[SIGN_POS]    = resMasked[topIdx];
      nextFlags[OVFL_POS]    = ovflBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      flagsOut <= '0;
    end else if (strobe.load) begin
      result   <= nextResult;
      flagsOut <= nextFlags;
    end
  end

  p_zero_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && strobe.zeroCnt |=> flagsOut == $past(flagsIn));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && !strobe.zeroCnt && !strobe.oneCnt |=> !flagsOut[OVFL_POS]);
  p_adjust_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && !strobe.zeroCnt |=> !flagsOut[ADJUST_POS]);
  p_byte_upper_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && strobe.widthCode == SZ_BYTE |=> result[DATA_W-1:8] == '0);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(result) && $stable(flagsOut));

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shift_flag_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 8,
  parameter int FLAG_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  operand,
  input  logic [COUNT_W-1:0] shiftCount,
  input  logic [1:0]         opSel,
  input  logic [1:0]         sizeSel,
  input  logic [FLAG_W-1:0]  flagsIn,
  output logic               outValid,
  output logic [DATA_W-1:0]  result,
  output logic [FLAG_W-1:0]  flagsOut
);

  shiftStrobe_t strobe;

  shift_ctrl #(.COUNT_W(COUNT_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .countIn  (shiftCount),
    .opSel    (opSel),
    .sizeSel  (sizeSel),
    .strobe   (strobe),
    .outValid (outValid)
  );

  shift_datapath #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .operand  (operand),
    .flagsIn  (flagsIn),
    .result   (result),
    .flagsOut (flagsOut)
  );

  p_reset_r11: assert property (@(posedge clk)
    !rstN |=> !outValid && result == '0 && flagsOut == '0);

endmodule

// File: tb/shift_flag_unit_tb_top.sv
`timescale 1ns/1ps
module shift_flag_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] operand = '0;
  logic [7:0]  shiftCount = '0;
  logic [1:0]  opSel = '0;
  logic [1:0]  sizeSel = '0;
  logic [15:0] flagsIn = '0;
  logic        outValid;
  logic [31:0] result;
  logic [15:0] flagsOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  shift_flag_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .operand(operand),
    .shiftCount(shiftCount), .opSel(opSel), .sizeSel(sizeSel),
    .flagsIn(flagsIn), .outValid(outValid), .result(result),
    .flagsOut(flagsOut)
  );

  // bit-serial reference built from the requirements
  function automatic void refModel(input logic [1:0] op, input logic [1:0] sz,
                                   input logic [31:0] a, input logic [7:0] cnt,
                                   input logic [15:0] fin,
                                   output logic [31:0] r, output logic [15:0] f);
    int w;
    int c;
    logic [31:0] mask;
    logic [31:0] v;
    logic cy;
    logic ov;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    c = int'(cnt[4:0]);
    v = a & mask;
    f = fin;
    cy = 1'b0;
    if (c == 0) begin
      r = v;
      return;
    end
    for (int i = 0; i < c; i++) begin
      if (op == 2'd1) begin
        cy = v[0];
        v = v >> 1;
      end else if (op == 2'd2) begin
        cy = v[0];
        v = (v >> 1) | (v[w-1] ? (32'h1 << (w-1)) : 32'h0);
      end else begin
        cy = v[w-1];
        v = (v << 1) & mask;
      end
    end
    ov = 1'b0;
    if (c == 1) begin
      if (op == 2'd1)      ov = a[w-1];
      else if (op == 2'd2) ov = 1'b0;
      else                 ov = cy ^ v[w-1];
    end
    r = v;
    f[0] = cy;
    f[2] = ~^v[7:0];
    f[4] = 1'b0;
    f[6] = (v == 32'h0);
    f[7] = v[w-1];
    f[11] = ov;
  endfunction

  task automatic check(input string req, input logic [31:0] gotR, input logic [31:0] expR,
                       input logic [15:0] gotF, input logic [15:0] expF,
                       input logic gotV, input logic expV);
    testsRun++;
    if (gotR !== expR || gotF !== expF || gotV !== expV) begin
      testsFailed++;
      $display("FAIL %s: result=%h flags=%h valid=%b expected result=%h flags=%h valid=%b",
               req, gotR, gotF, gotV, expR, expF, expV);
    end
  endtask

  // one request, checked on the following cycle
  task automatic runOp(input string req, input logic [1:0] op, input logic [1:0] sz,
                       input logic [31:0] a, input logic [7:0] cnt, input logic [15:0] fin);
    logic [31:0] er;
    logic [15:0] ef;
    refModel(op, sz, a, cnt, fin, er, ef);
    @(negedge clk);
    inValid = 1'b1; opSel = op; sizeSel = sz; operand = a;
    shiftCount = cnt; flagsIn = fin;
    @(negedge clk);
    check(req, result, er, flagsOut, ef, outValid, 1'b1);
    inValid = 1'b0;
  endtask

  task automatic testReset();
    // R11: registers cleared
    check("R11 reset", result, 32'h0, flagsOut, 16'h0, outValid, 1'b0);
  endtask

  task automatic testSweep(input string req, input logic [1:0] op);
    for (int s = 0; s < 3; s++)
      for (int c = 0; c < 32; c++) begin
        runOp(req, op, 2'(s), 32'h1234_5678, 8'(c), 16'h0000);
        runOp(req, op, 2'(s), 32'h8234_5678, 8'(c), 16'h0001);
        runOp(req, op, 2'(s), 32'h813f_a4a1, 8'(c), 16'hF7AE);
      end
  endtask

  task automatic testZeroCount();
    // R3: flags returned untouched, including bits the shift would change
    runOp("R3 zero count word", 2'd0, 2'd2, 32'hDEAD_BEEF, 8'd0, 16'hFFFF);
    runOp("R3 zero count byte", 2'd2, 2'd0, 32'hDEAD_BEEF, 8'd0, 16'h08D5);
    runOp("R3 zero count masked", 2'd1, 2'd1, 32'h0000_0000, 8'd32, 16'h0840);
  endtask

  task automatic testCountMask();
    // R2: count 33 acts like 1, 0xE3 like 3
    runOp("R2 count 33", 2'd0, 2'd2, 32'hC000_0001, 8'd33, 16'h0000);
    runOp("R2 count e3", 2'd1, 2'd1, 32'h0000_F00F, 8'hE3, 16'h0000);
    runOp("R2 count e3 sar", 2'd2, 2'd0, 32'h0000_0080, 8'hE3, 16'h0000);
  endtask

  task automatic testOverflow();
    // R6: count one rules and zero for larger counts
    runOp("R6 shl of set", 2'd0, 2'd0, 32'h0000_0040, 8'd1, 16'h0000);
    runOp("R6 shr of msb", 2'd1, 2'd1, 32'h0000_8000, 8'd1, 16'h0000);
    runOp("R6 sar of zero", 2'd2, 2'd2, 32'h8000_0000, 8'd1, 16'h0800);
    runOp("R6 count2 clears", 2'd0, 2'd2, 32'h4000_0000, 8'd2, 16'h0800);
  endtask

  task automatic testFlagsPass();
    // R7 and R8: unlisted bits follow flagsIn
    runOp("R8 pass ones", 2'd1, 2'd2, 32'h0000_0003, 8'd2, 16'hFFFF);
    runOp("R7 zero parity", 2'd1, 2'd0, 32'h0000_0001, 8'd1, 16'h0010);
  endtask

  task automatic testSizes();
    // R9: upper operand bits ignored, upper result bits zero
    runOp("R9 byte upper", 2'd0, 2'd0, 32'hFFFF_FF81, 8'd1, 16'h0000);
    runOp("R9 half sar", 2'd2, 2'd1, 32'hABCD_8000, 8'd4, 16'h0000);
    runOp("R9 word alt", 2'd1, 2'd3, 32'h8000_0000, 8'd31, 16'h0000);
  endtask

  task automatic testAltOp();
    // R4: opSel 3 is a left shift
    runOp("R4 alias left", 2'd3, 2'd2, 32'h8000_0001, 8'd1, 16'h0000);
    runOp("R4 past width", 2'd3, 2'd0, 32'h0000_00FF, 8'd9, 16'h0000);
  endtask

  task automatic testHold();
    logic [31:0] keepR;
    logic [15:0] keepF;
    runOp("R1 request", 2'd0, 2'd2, 32'h0F0F_0F0F, 8'd4, 16'h0000);
    keepR = result;
    keepF = flagsOut;
    @(negedge clk);
    operand = 32'hFFFF_FFFF; shiftCount = 8'd7; flagsIn = 16'hAAAA; opSel = 2'd2;
    @(negedge clk);
    // R10 and R1: no update, valid low
    check("R10 hold", result, keepR, flagsOut, keepF, outValid, 1'b0);
    @(negedge clk);
    check("R10 hold again", result, keepR, flagsOut, keepF, outValid, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    check("R11 after release", result, 32'h0, flagsOut, 16'h0, outValid, 1'b0);
    testSweep("R4 left sweep", 2'd0);
    testSweep("R5 logical right sweep", 2'd1);
    testSweep("R5 arithmetic right sweep", 2'd2);
    testZeroCount();
    testCountMask();
    testOverflow();
    testFlagsPass();
    testSizes();
    testAltOp();
    testHold();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule